// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block bulk-initialises the connection memory of a time-division switch. Software sets a global enable bit in one register, then writes a 5-bit fill value together with a start bit to a second register. On the rising edge of the start bit, the engine sweeps every memory address. Each word gets the fill value in its five most significant bits and zeros in the eleven bits below.

Frame pulses pace the sweep. The first frame pulse after the start edge opens the first frame, which writes the lower half of the address space. The second pulse opens the second frame, which writes the upper half. The third pulse ends the second frame. At that point the engine clears the start bit by itself, drops busy and raises a one-cycle done pulse. Clearing the start bit or the global enable bit during a fill aborts it. A host write port shares the memory when the engine is idle, and a synchronous read port lets the host inspect the contents.

Top module: `cm_fill_top`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `aux_o` are 0, and both registers read 0. The global register is at address 0 (bit 0 is the enable). The fill register is at address 1, with start at bit 0, fill value at bits 5:1 and auxiliary field at bits 7:6.
- R2: A fill starts only when a write to the fill register takes the start bit from 0 to 1 while the enable bit is 1. A start write with enable at 0 stores the bit but starts nothing. Writing start=1 again while it already reads 1 also starts nothing.
- R3: The fill value and start bit come from the same write. Every word written by the engine equals the fill value in bits 15:11 and zero in bits 10:0.
- R4: The engine writes no word before the first frame pulse after the start edge. The lower half of the addresses is written after that pulse, and the upper half only after the second pulse.
- R5: On the third frame pulse after the start edge the fill completes. `busy_o` falls, the start bit reads 0, and `done_o` is high for exactly one cycle.
- R6: `busy_o` is high from the clock edge that accepts the start write until completion or abort. The engine writes memory only while busy.
- R7: A register write with the start bit at 0 during a fill aborts it. The word in progress at that edge is written and later addresses keep their old contents. `busy_o` falls, and `done_o` stays low.
- R8: A write clearing the enable bit during a fill aborts it in the same way as R7 and also clears the start bit.
- R9: While busy, writes to the fill register do not change the fill value or the auxiliary field (`aux_o` and the read-back stay unchanged).
- R10: Host memory writes are ignored while busy and take effect when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 global, 1 fill |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| frame_i | input | 1 | Frame boundary pulse, one clock wide |
| mem_we_i | input | 1 | Host memory write strobe |
| mem_waddr_i | input | ADDR_W | Host write address |
| mem_wdata_i | input | DATA_W | Host write data |
| mem_raddr_i | input | ADDR_W | Read address |
| mem_rdata_o | output | DATA_W | Read data, one cycle after address |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | One-cycle completion pulse |
| aux_o | output | 2 | Auxiliary field of the fill register |

## Verification
Memory is first loaded with an address-dependent pattern, so a full fill shows which words were reached. Reading addresses at the half boundary between frame pulses separates the two sweep phases. A start with enable low and a repeated start with the bit already set test the edge-and-enable condition against a plain level check. Aborts by each of the two bits land part-way through a half. Reading the word at the abort edge and the word after it pins where writes stop, and fill-register writes during a fill confirm the frozen fields.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned START_BIT = 0;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned VAL_LSB   = 1;
  localparam int unsigned AUX_LSB   = 6;
  localparam logic        GLB_ADR   = 1'b0;
  localparam logic        FILL_ADR  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SWA,
    ST_GAP,
    ST_SWB,
    ST_TAIL
  } seq_st_e;
endpackage

// File: rtl/cmf_regs.sv
module cmf_regs
  import cmf_pkg::*;
#(
  parameter int unsigned FILL_W = 5,
  parameter int unsigned AUX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              fin_i,
  output logic              start_o,
  output logic              abort_o,
  output logic              en_o,
  output logic [FILL_W-1:0] fill_val_o,
  output logic [AUX_W-1:0]  aux_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic              en_q, start_q;
  logic [FILL_W-1:0] val_q;
  logic [AUX_W-1:0]  aux_q;
  logic              fill_wr, glb_wr;

  assign fill_wr = we_i && (addr_i == FILL_ADR);
  assign glb_wr  = we_i && (addr_i == GLB_ADR);

  // rising edge of start, gated by enable
  assign start_o = fill_wr && wdata_i[START_BIT] && !start_q && en_q && !busy_i;
  assign abort_o = busy_i && ((fill_wr && !wdata_i[START_BIT]) ||
                              (glb_wr && !wdata_i[EN_BIT]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      val_q   <= '0;
      aux_q   <= '0;
    end else begin
      if (glb_wr) en_q <= wdata_i[EN_BIT];
      if (fin_i || abort_o) start_q <= 1'b0;
      else if (fill_wr)     start_q <= wdata_i[START_BIT];
      if (fill_wr && !busy_i) begin
        val_q <= wdata_i[VAL_LSB +: FILL_W];
        aux_q <= wdata_i[AUX_LSB +: AUX_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == FILL_ADR) begin
      rdata_o[START_BIT]            = start_q;
      rdata_o[VAL_LSB +: FILL_W]    = val_q;
      rdata_o[AUX_LSB +: AUX_W]     = aux_q;
    end else begin
      rdata_o[EN_BIT] = en_q;
    end
  end

  assign en_o       = en_q;
  assign fill_val_o = val_q;
  assign aux_o      = aux_q;
endmodule

// File: rtl/cmf_seq.sv
module cmf_seq
  import cmf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              frame_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              done_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o
);
  localparam int unsigned       DEPTH     = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] HALF_LAST = ADDR_W'(DEPTH / 2 - 1);
  localparam logic [ADDR_W-1:0] LAST      = ADDR_W'(DEPTH - 1);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    fin_o  = 1'b0;
    we_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ARM;
      ST_ARM: if (frame_i) begin
        st_d   = ST_SWA;
        addr_d = '0;
      end
      ST_SWA: begin
        we_o   = 1'b1;
        addr_d = addr_q + 1'b1;
        if (addr_q == HALF_LAST) st_d = ST_GAP;
      end
      ST_GAP: if (frame_i) st_d = ST_SWB;
      ST_SWB: begin
        we_o   = 1'b1;
        addr_d = addr_q + 1'b1;
        if (addr_q == LAST) st_d = ST_TAIL;
      end
      ST_TAIL: if (frame_i) begin
        st_d  = ST_IDLE;
        fin_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    // word at the abort edge still commits
    if (abort_i) begin
      st_d  = ST_IDLE;
      fin_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      done_q <= fin_o;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign waddr_o = addr_q;
endmodule

// File: rtl/cmf_ram.sv
module cmf_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cm_fill_top.sv
module cm_fill_top
  import cmf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FILL_W = 5,
  parameter int unsigned AUX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              frame_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_waddr_i,
  input  logic [DATA_W-1:0] mem_wdata_i,
  input  logic [ADDR_W-1:0] mem_raddr_i,
  output logic [DATA_W-1:0] mem_rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [AUX_W-1:0]  aux_o
);
  localparam int unsigned LOW_W = DATA_W - FILL_W;

  logic              start_p, abort_p, fin_p, blk_en, eng_we;
  logic [FILL_W-1:0] fill_val;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_wdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  cmf_regs #(.FILL_W(FILL_W), .AUX_W(AUX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy_o),
    .fin_i     (fin_p),
    .start_o   (start_p),
    .abort_o   (abort_p),
    .en_o      (blk_en),
    .fill_val_o(fill_val),
    .aux_o     (aux_o),
    .rdata_o   (reg_rdata_o)
  );

  cmf_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_p),
    .abort_i(abort_p),
    .frame_i(frame_i),
    .busy_o (busy_o),
    .fin_o  (fin_p),
    .done_o (done_o),
    .we_o   (eng_we),
    .waddr_o(eng_addr)
  );

  assign eng_wdata = {fill_val, {LOW_W{1'b0}}};

  // engine owns the write port while busy
  assign ram_we    = busy_o ? eng_we    : mem_we_i;
  assign ram_waddr = busy_o ? eng_addr  : mem_waddr_i;
  assign ram_wdata = busy_o ? eng_wdata : mem_wdata_i;

  cmf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(ram_wdata),
    .raddr_i(mem_raddr_i),
    .rdata_o(mem_rdata_o)
  );
endmodule

// File: rtl/cmf_chk.sv
module cmf_chk #(
  parameter int unsigned AUX_W = 2,
  parameter int unsigned LOW_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic [AUX_W-1:0] aux_o,
  input logic             eng_we,
  input logic [LOW_W-1:0] eng_low,
  input logic             blk_en,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic             reg_bit0
);
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we |-> busy_o); // R6
  AST_WORD_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we |-> (eng_low == '0)); // R3
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> blk_en); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R5
  AST_EN_CLEAR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && !reg_addr_i && !reg_bit0) |=> !busy_o); // R8
  AST_START_CLEAR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && reg_addr_i && !reg_bit0) |=> (!busy_o && !done_o)); // R7
  AST_AUX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(aux_o)); // R9
endmodule

bind cm_fill_top cmf_chk #(.AUX_W(AUX_W), .LOW_W(DATA_W - FILL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .aux_o     (aux_o),
  .eng_we    (eng_we),
  .eng_low   (eng_wdata[DATA_W-FILL_W-1:0]),
  .blk_en    (blk_en),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .reg_bit0  (reg_wdata_i[0])
);

// File: tb/tb_cm_fill_top.sv
module tb_cm_fill_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we = 1'b0;
  logic              reg_addr = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              frame = 1'b0;
  logic              mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_waddr = '0;
  logic [DATA_W-1:0] mem_wdata = '0;
  logic [ADDR_W-1:0] mem_raddr = '0;
  logic [DATA_W-1:0] mem_rdata;
  logic              busy, done;
  logic [1:0]        aux;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cm_fill_top dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .frame_i(frame),
    .mem_we_i(mem_we), .mem_waddr_i(mem_waddr), .mem_wdata_i(mem_wdata),
    .mem_raddr_i(mem_raddr), .mem_rdata_o(mem_rdata),
    .busy_o(busy), .done_o(done), .aux_o(aux)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
  endtask

  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic mem_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); mem_raddr = a;
    @(negedge clk); d = mem_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 aux", aux, 0);
    reg_read(1'b0, r); chk("R1 glb reg", r, 8'h00);
    reg_read(1'b1, r); chk("R1 fill reg", r, 8'h00);
  endtask

  task automatic t_full_fill();
    logic [DATA_W-1:0] d;
    logic [7:0] r;
    int bad;
    for (int i = 0; i < DEPTH; i++) host_write(ADDR_W'(i), DATA_W'(16'h0100 + i));
    reg_write(1'b0, 8'h01);
    reg_write(1'b1, 8'h80 | (8'h15 << 1) | 8'h01);
    chk("R6 busy after start", busy, 1);
    ticks(10);
    mem_read(0, d); chk("R4 no write before frame", d, 16'h0100);
    host_write(40, 16'hDEAD);
    mem_read(40, d); chk("R10 host write ignored busy", d, 16'h0128);
    frame_pulse(); ticks(40);
    mem_read(31, d); chk("R3 lower half last word", d, 16'hA800);
    mem_read(32, d); chk("R4 upper half untouched", d, 16'h0120);
    chk("R6 busy mid fill", busy, 1);
    frame_pulse(); ticks(40);
    mem_read(63, d); chk("R4 upper half done", d, 16'hA800);
    chk("R5 busy before third frame", busy, 1);
    reg_read(1'b1, r); chk("R5 start still set", r[0], 1);
    frame_pulse();
    chk("R5 busy low", busy, 0);
    chk("R5 done pulse", done, 1);
    ticks(1);
    chk("R5 done one cycle", done, 0);
    reg_read(1'b1, r); chk("R5 start self-clears", r, 8'h80 | (8'h15 << 1));
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      mem_read(ADDR_W'(i), d);
      if (d !== 16'hA800) bad++;
    end
    chk("R3 all words filled", bad, 0);
    host_write(40, 16'h1234);
    mem_read(40, d); chk("R10 host write idle", d, 16'h1234);
    host_write(40, 16'hA800);
  endtask

  task automatic t_start_rules();
    logic [DATA_W-1:0] d;
    logic [7:0] r;
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h87);
    chk("R2 no start without enable", busy, 0);
    reg_read(1'b1, r); chk("R2 start bit stored", r, 8'h87);
    frame_pulse(); ticks(40); frame_pulse(); ticks(40); frame_pulse();
    mem_read(0, d); chk("R2 memory untouched", d, 16'hA800);
    reg_write(1'b0, 8'h01);
    chk("R2 enable alone no start", busy, 0);
    reg_write(1'b1, 8'h87);
    chk("R2 no edge no start", busy, 0);
    reg_write(1'b1, 8'h86);
    reg_write(1'b1, 8'h87);
    chk("R2 edge starts", busy, 1);
  endtask

  task automatic t_abort_start();
    logic [DATA_W-1:0] d;
    logic [7:0] r;
    frame_pulse(); ticks(5);
    reg_write(1'b1, 8'h7E);
    chk("R7 busy low", busy, 0);
    chk("R7 no done", done, 0);
    reg_read(1'b1, r); chk("R7 fields kept", r, 8'h86);
    chk("R9 aux kept", aux, 2'd2);
    mem_read(0, d); chk("R7 first word", d, 16'h1800);
    mem_read(6, d); chk("R7 abort-edge word", d, 16'h1800);
    mem_read(7, d); chk("R7 after abort untouched", d, 16'hA800);
    ticks(40); frame_pulse();
    mem_read(7, d); chk("R7 stays stopped", d, 16'hA800);
  endtask

  task automatic t_abort_en();
    logic [DATA_W-1:0] d;
    logic [7:0] r;
    reg_write(1'b1, 8'h55);
    chk("R2 restart", busy, 1);
    reg_write(1'b1, 8'hFF);
    reg_read(1'b1, r); chk("R9 fill reg frozen", r, 8'h55);
    chk("R9 aux frozen", aux, 2'd1);
    chk("R9 start write no abort", busy, 1);
    frame_pulse(); ticks(40); frame_pulse(); ticks(3);
    reg_write(1'b0, 8'h00);
    chk("R8 busy low", busy, 0);
    chk("R8 no done", done, 0);
    reg_read(1'b1, r); chk("R8 start cleared", r, 8'h54);
    mem_read(31, d); chk("R8 lower half", d, 16'h5000);
    mem_read(36, d); chk("R8 abort-edge word", d, 16'h5000);
    mem_read(37, d); chk("R8 after abort untouched", d, 16'hA800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_full_fill();
    t_start_rules();
    t_abort_start();
    t_abort_en();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule